// File: doc/BRIEF.md
# Function-Unit to Register Dependency Matrix

This block tracks which function units still have to read or write which registers of one register file. It is a grid with one row per function unit and one column per register. Each grid position keeps its own clocked set-reset latch for every register-file read port and for every write port, so a unit that reads the same register through two ports holds two separate marks.

When an instruction is issued, a one-hot unit select names the row. For each read port and each write port, a valid flag and a one-hot register select name the column whose latch is set. A later grant pulse for one unit and one port clears only that latch. A cancel pulse for a unit clears its whole row.

The grid reports three things. Each register gets a read-pending flag and a write-pending flag. Each unit and read port gets a source-ready flag, which is high when no other unit still has to write the register that port is waiting to read. Each register file needs its own instance. The instances share no state.

Top module: `fu_reg_dep_matrix`

## Requirements
- R1: After reset every latch is clear. Every rdPendReg and wrPendReg bit is 0, and every srcReady bit is 1.
- R2: When issueFu[f] is high and rdValid[p] is high, the read latch of unit f, port p is set for the register chosen by rdRegSel[p*NUM_REGS +: NUM_REGS]. rdPendReg for that register is high from the next cycle on.
- R3: When issueFu[f] is high and wrValid[w] is high, the write latch of unit f, port w is set for the register chosen by wrRegSel[w*NUM_REGS +: NUM_REGS]. wrPendReg for that register is high from the next cycle on.
- R4: A port whose valid flag is low during issue sets no latch, whatever its register select holds.
- R5: A pulse on rdGrant[f*NUM_RD+p] clears every read latch of unit f, port p. It leaves unit f's other ports untouched.
- R6: A pulse on wrGrant[f*NUM_WR+w] clears every write latch of unit f, write port w.
- R7: A pulse on cancelFu[f] clears every read and write latch of unit f in one cycle.
- R8: When a clear (grant or cancel) and a set reach the same latch in the same cycle, the clear wins.
- R9: rdPendReg[r] is the OR of all read latches in column r. wrPendReg[r] is the OR of all write latches in column r.
- R10: srcReady[f*NUM_RD+p] is low exactly when unit f, port p holds a read latch on some register for which a unit other than f holds a write latch. A unit's own writes never block it.
- R11: Bit f of every per-unit vector refers to the same unit f. Per-unit, per-port vectors use bit f*NUM_RD+p for read ports and bit f*NUM_WR+w for write ports. At most one bit of issueFu is high, and each port's register select is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueFu | input | NUM_FU | One-hot select of the unit being issued |
| rdValid | input | NUM_RD | Per read port: a source operand uses this port |
| rdRegSel | input | NUM_RD*NUM_REGS | Per read port: one-hot source register |
| wrValid | input | NUM_WR | Per write port: a destination uses this port |
| wrRegSel | input | NUM_WR*NUM_REGS | Per write port: one-hot destination register |
| rdGrant | input | NUM_FU*NUM_RD | Read-port grant pulse per unit and port |
| wrGrant | input | NUM_FU*NUM_WR | Write-port grant pulse per unit and port |
| cancelFu | input | NUM_FU | Per-unit cancel pulse |
| rdPendReg | output | NUM_REGS | Per register: some unit still has to read it |
| wrPendReg | output | NUM_REGS | Per register: some unit still has to write it |
| srcReady | output | NUM_FU*NUM_RD | Per unit and read port: source not blocked by another unit's write |

## Verification
The bench builds the grid with 5 registers, 4 units, 3 read ports and 2 write ports. These four counts all differ, so a swapped index, a stride taken from the wrong parameter, or a grant routed to the wrong latch moves bits to positions the reference model does not expect. With three read ports, one unit can hold a valid port, a second valid port on the register it writes itself, and an invalid port in a single issue. With four units, cancels, grants and new issues overlap on different rows in the same cycle.

// File: rtl/fu_reg_dep_ctrl.sv
module fu_reg_dep_ctrl #(
  parameter int NUM_REGS = 4,
  parameter int NUM_FU   = 3,
  parameter int NUM_RD   = 2,
  parameter int NUM_WR   = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_FU-1:0]               issueFu,
  input  logic [NUM_RD-1:0]               rdValid,
  input  logic [NUM_RD*NUM_REGS-1:0]      rdRegSel,
  input  logic [NUM_WR-1:0]               wrValid,
  input  logic [NUM_WR*NUM_REGS-1:0]      wrRegSel,
  input  logic [NUM_FU*NUM_RD-1:0]        rdGrant,
  input  logic [NUM_FU*NUM_WR-1:0]        wrGrant,
  input  logic [NUM_FU-1:0]               cancelFu,
  output logic [NUM_FU*NUM_RD*NUM_REGS-1:0] rdSet,
  output logic [NUM_FU*NUM_RD-1:0]        rdClr,
  output logic [NUM_FU*NUM_WR*NUM_REGS-1:0] wrSet,
  output logic [NUM_FU*NUM_WR-1:0]        wrClr
);
  // Strobes per latch row: a row is one unit and one port, spanning all registers.
  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      localparam int ROW = f*NUM_RD + p;
      assign rdClr[ROW] = rdGrant[ROW] | cancelFu[f];
      assign rdSet[ROW*NUM_REGS +: NUM_REGS] =
        {NUM_REGS{issueFu[f] & rdValid[p]}} & rdRegSel[p*NUM_REGS +: NUM_REGS];
    end
    for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
      localparam int ROW = f*NUM_WR + w;
      assign wrClr[ROW] = wrGrant[ROW] | cancelFu[f];
      assign wrSet[ROW*NUM_REGS +: NUM_REGS] =
        {NUM_REGS{issueFu[f] & wrValid[w]}} & wrRegSel[w*NUM_REGS +: NUM_REGS];
    end
  end

  // R11: issue names at most one unit
  assert_issue_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueFu));

  for (genvar p = 0; p < NUM_RD; p++) begin : g_chkRd
    // R11: each read-port select is one-hot or zero
    assert_rdsel_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(rdRegSel[p*NUM_REGS +: NUM_REGS]));
  end
  for (genvar w = 0; w < NUM_WR; w++) begin : g_chkWr
    // R11: each write-port select is one-hot or zero
    assert_wrsel_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(wrRegSel[w*NUM_REGS +: NUM_REGS]));
  end
endmodule

// File: rtl/fu_reg_dep_grid.sv
module fu_reg_dep_grid #(
  parameter int NUM_REGS = 4,
  parameter int NUM_FU   = 3,
  parameter int NUM_RD   = 2,
  parameter int NUM_WR   = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_FU*NUM_RD*NUM_REGS-1:0] rdSet,
  input  logic [NUM_FU*NUM_RD-1:0]          rdClr,
  input  logic [NUM_FU*NUM_WR*NUM_REGS-1:0] wrSet,
  input  logic [NUM_FU*NUM_WR-1:0]          wrClr,
  output logic [NUM_REGS-1:0]               rdPendReg,
  output logic [NUM_REGS-1:0]               wrPendReg,
  output logic [NUM_FU*NUM_RD-1:0]          srcReady
);
  localparam int RD_ROWS = NUM_FU*NUM_RD;
  localparam int WR_ROWS = NUM_FU*NUM_WR;
  localparam int RD_BITS = RD_ROWS*NUM_REGS;
  localparam int WR_BITS = WR_ROWS*NUM_REGS;

  logic [RD_BITS-1:0] rdQ, rdClrWide;
  logic [WR_BITS-1:0] wrQ, wrClrWide;
  logic [NUM_REGS-1:0] wrByFu  [NUM_FU];
  logic [NUM_REGS-1:0] wrOther [NUM_FU];

  for (genvar i = 0; i < RD_ROWS; i++) begin : g_rdWide
    assign rdClrWide[i*NUM_REGS +: NUM_REGS] = {NUM_REGS{rdClr[i]}};
  end
  for (genvar i = 0; i < WR_ROWS; i++) begin : g_wrWide
    assign wrClrWide[i*NUM_REGS +: NUM_REGS] = {NUM_REGS{wrClr[i]}};
  end

  // Set-reset latches; the clear term is applied last so it dominates.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
      wrQ <= '0;
    end else begin
      rdQ <= (rdQ | rdSet) & ~rdClrWide;
      wrQ <= (wrQ | wrSet) & ~wrClrWide;
    end
  end

  // Column ORs
  always_comb begin
    rdPendReg = '0;
    wrPendReg = '0;
    for (int i = 0; i < RD_ROWS; i++) rdPendReg |= rdQ[i*NUM_REGS +: NUM_REGS];
    for (int i = 0; i < WR_ROWS; i++) wrPendReg |= wrQ[i*NUM_REGS +: NUM_REGS];
  end

  // Registers each unit still has to write, and those written by all other units
  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      wrByFu[f] = '0;
      for (int w = 0; w < NUM_WR; w++) wrByFu[f] |= wrQ[(f*NUM_WR + w)*NUM_REGS +: NUM_REGS];
    end
    for (int f = 0; f < NUM_FU; f++) begin
      wrOther[f] = '0;
      for (int g = 0; g < NUM_FU; g++)
        if (g != f) wrOther[f] |= wrByFu[g];
    end
  end

  always_comb begin
    for (int f = 0; f < NUM_FU; f++)
      for (int p = 0; p < NUM_RD; p++)
        srcReady[f*NUM_RD + p] = ~|(rdQ[(f*NUM_RD + p)*NUM_REGS +: NUM_REGS] & wrOther[f]);
  end

  for (genvar i = 0; i < RD_ROWS; i++) begin : g_rdChk
    // R8: a clear leaves the read row empty whatever was set
    assert_rd_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      rdClr[i] |=> (rdQ[i*NUM_REGS +: NUM_REGS] == '0));
    // R2: a set without clear is held next cycle
    assert_rd_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!rdClr[i] && (rdSet[i*NUM_REGS +: NUM_REGS] != '0)) |=>
      ((rdQ[i*NUM_REGS +: NUM_REGS] & $past(rdSet[i*NUM_REGS +: NUM_REGS]))
        == $past(rdSet[i*NUM_REGS +: NUM_REGS])));
    // R5: without strobes a read row keeps its value
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (!rdClr[i] && (rdSet[i*NUM_REGS +: NUM_REGS] == '0)) |=>
      $stable(rdQ[i*NUM_REGS +: NUM_REGS]));
  end
  for (genvar i = 0; i < WR_ROWS; i++) begin : g_wrChk
    // R6: a write clear empties the row
    assert_wr_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      wrClr[i] |=> (wrQ[i*NUM_REGS +: NUM_REGS] == '0));
    // R3: a write set without clear is held
    assert_wr_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!wrClr[i] && (wrSet[i*NUM_REGS +: NUM_REGS] != '0)) |=>
      ((wrPendReg & $past(wrSet[i*NUM_REGS +: NUM_REGS]))
        == $past(wrSet[i*NUM_REGS +: NUM_REGS])));
  end
endmodule

// File: rtl/fu_reg_dep_matrix.sv
module fu_reg_dep_matrix #(
  parameter int NUM_REGS = 4,
  parameter int NUM_FU   = 3,
  parameter int NUM_RD   = 2,
  parameter int NUM_WR   = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_FU-1:0]          issueFu,
  input  logic [NUM_RD-1:0]          rdValid,
  input  logic [NUM_RD*NUM_REGS-1:0] rdRegSel,
  input  logic [NUM_WR-1:0]          wrValid,
  input  logic [NUM_WR*NUM_REGS-1:0] wrRegSel,
  input  logic [NUM_FU*NUM_RD-1:0]   rdGrant,
  input  logic [NUM_FU*NUM_WR-1:0]   wrGrant,
  input  logic [NUM_FU-1:0]          cancelFu,
  output logic [NUM_REGS-1:0]        rdPendReg,
  output logic [NUM_REGS-1:0]        wrPendReg,
  output logic [NUM_FU*NUM_RD-1:0]   srcReady
);
  localparam int RD_BITS = NUM_FU*NUM_RD*NUM_REGS;
  localparam int WR_BITS = NUM_FU*NUM_WR*NUM_REGS;

  logic [RD_BITS-1:0]       rdSet;
  logic [NUM_FU*NUM_RD-1:0] rdClr;
  logic [WR_BITS-1:0]       wrSet;
  logic [NUM_FU*NUM_WR-1:0] wrClr;

  fu_reg_dep_ctrl #(.NUM_REGS(NUM_REGS), .NUM_FU(NUM_FU), .NUM_RD(NUM_RD), .NUM_WR(NUM_WR)) ctrl (
    .clk(clk), .rstN(rstN), .issueFu(issueFu), .rdValid(rdValid), .rdRegSel(rdRegSel),
    .wrValid(wrValid), .wrRegSel(wrRegSel), .rdGrant(rdGrant), .wrGrant(wrGrant),
    .cancelFu(cancelFu), .rdSet(rdSet), .rdClr(rdClr), .wrSet(wrSet), .wrClr(wrClr));

  fu_reg_dep_grid #(.NUM_REGS(NUM_REGS), .NUM_FU(NUM_FU), .NUM_RD(NUM_RD), .NUM_WR(NUM_WR)) grid (
    .clk(clk), .rstN(rstN), .rdSet(rdSet), .rdClr(rdClr), .wrSet(wrSet), .wrClr(wrClr),
    .rdPendReg(rdPendReg), .wrPendReg(wrPendReg), .srcReady(srcReady));

  // R7: a cancel with no matching issue leaves nothing pending for a register
  // that no other unit touches is not expressible here; instead check the port effect:
  // an issued write with no clear on its unit shows as pending next cycle (R3).
  for (genvar f = 0; f < NUM_FU; f++) begin : g_top
    assert_issue_write_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
      (issueFu[f] && !cancelFu[f] && wrValid[0] && !wrGrant[f*NUM_WR]) |=>
      ((wrPendReg & $past(wrRegSel[NUM_REGS-1:0])) == $past(wrRegSel[NUM_REGS-1:0])));
  end
endmodule

// File: tb/tb_fu_reg_dep_matrix.sv
module tb_fu_reg_dep_matrix;
  localparam int NR  = 5;
  localparam int NF  = 4;
  localparam int NRD = 3;
  localparam int NWR = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NF-1:0]      issueFu;
  logic [NRD-1:0]     rdValid;
  logic [NRD*NR-1:0]  rdRegSel;
  logic [NWR-1:0]     wrValid;
  logic [NWR*NR-1:0]  wrRegSel;
  logic [NF*NRD-1:0]  rdGrant;
  logic [NF*NWR-1:0]  wrGrant;
  logic [NF-1:0]      cancelFu;
  logic [NR-1:0]      rdPendReg, wrPendReg;
  logic [NF*NRD-1:0]  srcReady;

  int checks = 0;
  int fails = 0;
  bit mdlRd [NF][NRD][NR];
  bit mdlWr [NF][NWR][NR];

  always #5 clk = ~clk;

  fu_reg_dep_matrix #(.NUM_REGS(NR), .NUM_FU(NF), .NUM_RD(NRD), .NUM_WR(NWR)) dut (
    .clk(clk), .rstN(rstN), .issueFu(issueFu), .rdValid(rdValid), .rdRegSel(rdRegSel),
    .wrValid(wrValid), .wrRegSel(wrRegSel), .rdGrant(rdGrant), .wrGrant(wrGrant),
    .cancelFu(cancelFu), .rdPendReg(rdPendReg), .wrPendReg(wrPendReg), .srcReady(srcReady));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    issueFu = '0; rdValid = '0; rdRegSel = '0; wrValid = '0; wrRegSel = '0;
    rdGrant = '0; wrGrant = '0; cancelFu = '0;
  endtask

  task automatic setRd(int p, int r, bit v);
    rdValid[p] = v;
    rdRegSel[p*NR +: NR] = NR'(1) << r;
  endtask

  task automatic setWr(int w, int r, bit v);
    wrValid[w] = v;
    wrRegSel[w*NR +: NR] = NR'(1) << r;
  endtask

  function automatic logic [NR-1:0] expRdPend();
    logic [NR-1:0] v = '0;
    for (int f = 0; f < NF; f++) for (int p = 0; p < NRD; p++) for (int r = 0; r < NR; r++)
      if (mdlRd[f][p][r]) v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [NR-1:0] expWrPend();
    logic [NR-1:0] v = '0;
    for (int f = 0; f < NF; f++) for (int w = 0; w < NWR; w++) for (int r = 0; r < NR; r++)
      if (mdlWr[f][w][r]) v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [NF*NRD-1:0] expReady();
    logic [NF*NRD-1:0] v = '1;
    for (int f = 0; f < NF; f++) for (int p = 0; p < NRD; p++) for (int r = 0; r < NR; r++)
      if (mdlRd[f][p][r])
        for (int g = 0; g < NF; g++) for (int w = 0; w < NWR; w++)
          if (g != f && mdlWr[g][w][r]) v[f*NRD + p] = 1'b0;
    return v;
  endfunction

  // Advance one clock, update the model from the driven inputs, sample at the falling edge
  task automatic step();
    @(posedge clk);
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < NRD; p++)
        for (int r = 0; r < NR; r++)
          if (rdGrant[f*NRD + p] || cancelFu[f]) mdlRd[f][p][r] = 1'b0;
          else if (issueFu[f] && rdValid[p] && rdRegSel[p*NR + r]) mdlRd[f][p][r] = 1'b1;
      for (int w = 0; w < NWR; w++)
        for (int r = 0; r < NR; r++)
          if (wrGrant[f*NWR + w] || cancelFu[f]) mdlWr[f][w][r] = 1'b0;
          else if (issueFu[f] && wrValid[w] && wrRegSel[w*NR + r]) mdlWr[f][w][r] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic chkModel();
    chk("R9 rdPendReg", 32'(rdPendReg), 32'(expRdPend()));
    chk("R9 wrPendReg", 32'(wrPendReg), 32'(expWrPend()));
    chk("R10 srcReady", 32'(srcReady), 32'(expReady()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    clearIn();
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < NRD; p++) for (int r = 0; r < NR; r++) mdlRd[f][p][r] = 1'b0;
      for (int w = 0; w < NWR; w++) for (int r = 0; r < NR; r++) mdlWr[f][w][r] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdPendReg", 32'(rdPendReg), 32'h0);
    chk("R1 wrPendReg", 32'(wrPendReg), 32'h0);
    chk("R1 srcReady", 32'(srcReady), 32'hFFF);

    // Unit 1: port0 reads r2, port1 reads r4, port2 invalid on r3, writes r4 on wr0
    clearIn(); issueFu = 4'b0010;
    setRd(0, 2, 1); setRd(1, 4, 1); setRd(2, 3, 0); setWr(0, 4, 1);
    step();
    chk("R2 rdPendReg", 32'(rdPendReg), 32'h14);
    chk("R3 wrPendReg", 32'(wrPendReg), 32'h10);
    chk("R4 invalid port r3 not pending", 32'(rdPendReg[3]), 32'h0);
    chk("R10 own write does not block", 32'(srcReady[1*NRD+1]), 32'h1);

    // Unit 0 port2 reads r4, which unit 1 writes
    clearIn(); issueFu = 4'b0001; setRd(2, 4, 1);
    step();
    chk("R10 blocked by other writer", 32'(srcReady[0*NRD+2]), 32'h0);
    chk("R11 srcReady bit layout", 32'(srcReady), 32'hFFB);

    // Write grant for unit 1 port 0
    clearIn(); wrGrant[1*NWR+0] = 1'b1;
    step();
    chk("R6 wrPendReg", 32'(wrPendReg), 32'h0);
    chk("R6 unblocked", 32'(srcReady[0*NRD+2]), 32'h1);

    // Read grant for unit 1 port 0 only
    clearIn(); rdGrant[1*NRD+0] = 1'b1;
    step();
    chk("R5 rdPendReg", 32'(rdPendReg), 32'h10);

    // Cancel unit 1 while issuing it again: clear wins
    clearIn(); cancelFu = 4'b0010; issueFu = 4'b0010; setRd(0, 0, 1); setWr(1, 1, 1);
    step();
    chk("R8 rdPendReg", 32'(rdPendReg), 32'h10);
    chk("R8 wrPendReg", 32'(wrPendReg), 32'h0);

    // Grant unit 0 port2: r4 drops only if unit 1's port1 latch was cancelled
    clearIn(); rdGrant[0*NRD+2] = 1'b1;
    step();
    chk("R7 rdPendReg", 32'(rdPendReg), 32'h0);
    chkModel();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      clearIn();
      if ($urandom_range(1, 0) == 1) issueFu = NF'(1) << $urandom_range(NF-1, 0);
      for (int p = 0; p < NRD; p++) setRd(p, $urandom_range(NR-1, 0), 1'($urandom_range(1, 0)));
      for (int w = 0; w < NWR; w++) setWr(w, $urandom_range(NR-1, 0), 1'($urandom_range(1, 0)));
      for (int i = 0; i < NF*NRD; i++) rdGrant[i] = ($urandom_range(7, 0) == 0);
      for (int i = 0; i < NF*NWR; i++) wrGrant[i] = ($urandom_range(7, 0) == 0);
      for (int i = 0; i < NF; i++) cancelFu[i] = ($urandom_range(15, 0) == 0);
      step();
      chkModel();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule